// File: doc/BRIEF.md
# I2C SCL Bit Timing Generator

This block sits between an I2C master's protocol engine and the SCL pad. It turns four programmable counts, all in cycles of the internal clock, into the shape of the SCL clock. The four counts are the full bit period, the SCL low time, the setup time before a START or STOP edge on SDA, and the data setup point after the falling SCL edge. The protocol engine asks for one phase at a time: a data bit, a START, a repeated START or a STOP. The generator then runs that phase and reports its progress with single-cycle ticks. There is a tick for the SCL falling edge, one for the SCL rising edge, one for the point where SDA may change, one for the START/STOP point and one for the last cycle of the phase.

SCL is open-drain. The block drives `scl_oe` high to pull the line low, and leaves it low to let the line float high. Two control inputs hold the bus while software changes the counts. `run_en` enables normal operation. `scl_free` releases an SCL line that is being held low. Phases run only while both inputs are 1. For a 50 MHz internal clock, the usual settings are: period = clock rate / bus rate, low time = setup time = period/2, and data setup = period/16. At the top rate of 400 kHz this gives a period of 125. A byte with its ACK takes nine bit phases.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, with `run_en`=1, `scl_free`=1 and no request, `busy`, `scl_oe`, `phase_done` and all ticks are 0.
- R2: The generator accepts a bit request (`op`=0) on a clock edge. From the next cycle it runs a bit phase of Pe cycles. `scl_oe` is 1 for the first Le cycles and 0 for the remaining cycles. `tick_fall` marks the first cycle, `tick_rise` marks cycle Le, `phase_done` marks cycle Pe-1, and `busy` is 1 throughout.
- R3: In a bit phase, `tick_data` fires exactly once, at cycle De counted from the `tick_fall` cycle (cycle 0), while SCL is still driven low.
- R4: A START, repeated START or STOP phase lasts 2*Se cycles with `scl_oe`=0 in every cycle. `tick_start` or `tick_stop` fires at cycle Se, and `phase_done` fires on the last cycle.
- R5: The counts and the `op` value are captured only on the edge that accepts a request. Changes to `cfg_*` while a phase runs do not affect that phase.
- R6: The clamps are Pe = max(`cfg_period`, 4); Le = `cfg_low` limited to the range [2, Pe-1]; De = `cfg_dsetup` limited to the range [1, Le-1]; and Se = `cfg_susto`, or 1 if `cfg_susto` is 0.
- R7: A 0 on `run_en` or `scl_free` aborts any phase. `busy` is 0 from the next cycle, and `go` is ignored while the hold lasts.
- R8: While held, `scl_oe` = NOT `scl_free`. `scl_free`=0 keeps SCL pulled low, and `scl_free`=1 releases it.
- R9: A request is accepted only when the generator is idle or `phase_done` is 1. A request in the `phase_done` cycle starts the next phase on the following cycle with no gap. A request at any other time during a phase is ignored.
- R10: The `op` encoding is 0 = data bit, 1 = START, 2 = STOP, 3 = repeated START. Codes 1 and 3 produce `tick_start`, and code 2 produces `tick_stop`.
- R11: At most one of `tick_fall`, `tick_rise`, `tick_data`, `tick_start` and `tick_stop` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | Normal operation enable |
| scl_free | input | 1 | Release SCL; 0 pulls SCL low while held |
| cfg_period | input | CNT_W | Full bit period count |
| cfg_low | input | CNT_W | SCL low count |
| cfg_dsetup | input | CNT_W | Data change point after the falling edge |
| cfg_susto | input | CNT_W | START/STOP setup count |
| go | input | 1 | Phase request |
| op | input | 2 | Phase kind (see R10) |
| scl_oe | output | 1 | 1 pulls SCL low |
| tick_fall | output | 1 | SCL falling edge cycle |
| tick_rise | output | 1 | SCL rising edge cycle |
| tick_data | output | 1 | SDA may change |
| tick_start | output | 1 | SDA edge point for START or repeated START |
| tick_stop | output | 1 | SDA edge point for STOP |
| phase_done | output | 1 | Last cycle of the current phase |
| busy | output | 1 | A phase is running |

## Verification
Every output is decoded from the phase register, the counter and the captured counts, so a wrong internal state reaches the ports in the cycle where it occurs. A counter off by one moves an SCL edge or tick by exactly one cycle. A stale captured count changes the length of the next phase. A phase register that fails to return to idle keeps `busy` high past `phase_done`. The bench predicts every output bit for every cycle of each phase, so a mismatch is reported in the first cycle it appears. Back-to-back requests, requests that arrive mid-phase, count changes mid-phase, clamps and hold-off aborts are each driven on their own.

// File: rtl/scl_timing_pkg.sv
`timescale 1ns/1ps
package scl_timing_pkg;

  typedef enum logic [1:0] {
    OP_BIT    = 2'd0,
    OP_START  = 2'd1,
    OP_STOP   = 2'd2,
    OP_RSTART = 2'd3
  } scl_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BIT   = 2'd1,
    PH_SETUP = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_count_sel.sv
`timescale 1ns/1ps
// Clamps the raw timing counts and captures them when a phase is accepted.
module scl_count_sel #(
  parameter int CNT_W   = 12,
  parameter int MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] raw_per,
  input  logic [CNT_W-1:0] raw_low,
  input  logic [CNT_W-1:0] raw_dset,
  input  logic [CNT_W-1:0] raw_sset,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] dset_q,
  output logic [CNT_W-1:0] sset_q
);

  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] per_d, low_d, dset_d, sset_d;
  logic [CNT_W-1:0] low_max, dset_max;

  always_comb begin
    per_d    = (raw_per < PER_MIN) ? PER_MIN : raw_per;
    low_max  = per_d - ONE;
    if (raw_low < TWO)          low_d = TWO;
    else if (raw_low > low_max) low_d = low_max;
    else                        low_d = raw_low;
    dset_max = low_d - ONE;
    if (raw_dset < ONE)           dset_d = ONE;
    else if (raw_dset > dset_max) dset_d = dset_max;
    else                          dset_d = raw_dset;
    sset_d   = (raw_sset == '0) ? ONE : raw_sset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PER_MIN;
      low_q  <= TWO;
      dset_q <= ONE;
      sset_q <= ONE;
    end else if (load) begin
      per_q  <= per_d;
      low_q  <= low_d;
      dset_q <= dset_d;
      sset_q <= sset_d;
    end
  end

endmodule

// File: rtl/scl_phase_ctrl.sv
`timescale 1ns/1ps
// Phase register and cycle counter.
module scl_phase_ctrl
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             operate,
  input  logic             go,
  input  scl_op_e          op_in,
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W-1:0] sset_q,
  output scl_phase_e       phase,
  output logic [CNT_W:0]   cnt,
  output scl_op_e          op_q,
  output logic             last,
  output logic             accept
);

  localparam int CW = CNT_W + 1;

  logic [CW-1:0] bit_end, set_end, cnt_d;
  scl_phase_e    phase_d;
  scl_op_e       op_d;

  always_comb begin
    bit_end = {1'b0, per_q} - CW'(1);
    set_end = {sset_q, 1'b0} - CW'(1);
    last    = ((phase == PH_BIT)   && (cnt == bit_end)) ||
              ((phase == PH_SETUP) && (cnt == set_end));
    accept  = go && operate && ((phase == PH_IDLE) || last);

    phase_d = phase;
    cnt_d   = cnt;
    op_d    = op_q;
    if (!operate) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (accept) begin
      phase_d = (op_in == OP_BIT) ? PH_BIT : PH_SETUP;
      cnt_d   = '0;
      op_d    = op_in;
    end else if (last) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (phase != PH_IDLE) begin
      cnt_d   = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      op_q  <= OP_BIT;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
      op_q  <= op_d;
    end
  end

endmodule

// File: rtl/scl_tick_decode.sv
`timescale 1ns/1ps
// Decodes the pad enable and the phase ticks from the phase state.
module scl_tick_decode
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             run_en,
  input  logic             scl_free,
  input  scl_phase_e       phase,
  input  logic [CNT_W:0]   cnt,
  input  scl_op_e          op_q,
  input  logic [CNT_W-1:0] low_q,
  input  logic [CNT_W-1:0] dset_q,
  input  logic [CNT_W-1:0] sset_q,
  output logic             scl_oe,
  output logic             tick_fall,
  output logic             tick_rise,
  output logic             tick_data,
  output logic             tick_start,
  output logic             tick_stop
);

  logic in_bit, in_set, set_hit;

  always_comb begin
    in_bit     = (phase == PH_BIT);
    in_set     = (phase == PH_SETUP);
    tick_fall  = in_bit && (cnt == '0);
    tick_data  = in_bit && (cnt == {1'b0, dset_q});
    tick_rise  = in_bit && (cnt == {1'b0, low_q});
    set_hit    = in_set && (cnt == {1'b0, sset_q});
    tick_start = set_hit && (op_q != OP_STOP);
    tick_stop  = set_hit && (op_q == OP_STOP);
    if (run_en && scl_free) scl_oe = in_bit && (cnt < {1'b0, low_q});
    else                    scl_oe = !scl_free;
  end

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             scl_free,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_dsetup,
  input  logic [CNT_W-1:0] cfg_susto,
  input  logic             go,
  input  logic [1:0]       op,
  output logic             scl_oe,
  output logic             tick_fall,
  output logic             tick_rise,
  output logic             tick_data,
  output logic             tick_start,
  output logic             tick_stop,
  output logic             phase_done,
  output logic             busy
);

  logic             operate, accept, last;
  logic [CNT_W-1:0] per_q, low_q, dset_q, sset_q;
  logic [CNT_W:0]   cnt;
  scl_phase_e       phase;
  scl_op_e          op_q;

  assign operate = run_en && scl_free;

  scl_count_sel #(.CNT_W(CNT_W), .MIN_PER(MIN_PER)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .raw_per(cfg_period), .raw_low(cfg_low),
    .raw_dset(cfg_dsetup), .raw_sset(cfg_susto),
    .per_q(per_q), .low_q(low_q), .dset_q(dset_q), .sset_q(sset_q)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .operate(operate), .go(go),
    .op_in(scl_op_e'(op)), .per_q(per_q), .sset_q(sset_q),
    .phase(phase), .cnt(cnt), .op_q(op_q), .last(last), .accept(accept)
  );

  scl_tick_decode #(.CNT_W(CNT_W)) u_dec (
    .run_en(run_en), .scl_free(scl_free), .phase(phase), .cnt(cnt),
    .op_q(op_q), .low_q(low_q), .dset_q(dset_q), .sset_q(sset_q),
    .scl_oe(scl_oe), .tick_fall(tick_fall), .tick_rise(tick_rise),
    .tick_data(tick_data), .tick_start(tick_start), .tick_stop(tick_stop)
  );

  assign phase_done = last;
  assign busy       = (phase != PH_IDLE);

endmodule

// File: rtl/scl_timing_chk.sv
`timescale 1ns/1ps
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_free,
  input logic scl_oe,
  input logic tick_fall,
  input logic tick_rise,
  input logic tick_data,
  input logic tick_start,
  input logic tick_stop,
  input logic phase_done,
  input logic busy
);

  p_one_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_fall, tick_rise, tick_data, tick_start, tick_stop}));

  p_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_free && tick_fall) |-> scl_oe);

  p_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_free && tick_rise) |-> !scl_oe);

  p_done_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> busy);

  p_data_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_free && tick_data) |-> scl_oe);

  p_setup_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_free && (tick_start || tick_stop)) |-> !scl_oe);

  p_hold_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && scl_free) |=> !busy);

  p_stuck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_free) |-> scl_oe);

  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && scl_free) |-> !scl_oe);

  p_no_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_free && busy && !phase_done) |=> busy);

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_free(scl_free),
  .scl_oe(scl_oe), .tick_fall(tick_fall), .tick_rise(tick_rise),
  .tick_data(tick_data), .tick_start(tick_start), .tick_stop(tick_stop),
  .phase_done(phase_done), .busy(busy)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

  localparam int CW = 12;

  logic          clk;
  logic          rst_n;
  logic          run_en, scl_free, go;
  logic [1:0]    op;
  logic [CW-1:0] cfg_period, cfg_low, cfg_dsetup, cfg_susto;
  logic          scl_oe, tick_fall, tick_rise, tick_data, tick_start, tick_stop;
  logic          phase_done, busy;

  scl_timing_gen #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_free(scl_free),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_dsetup(cfg_dsetup),
    .cfg_susto(cfg_susto), .go(go), .op(op), .scl_oe(scl_oe),
    .tick_fall(tick_fall), .tick_rise(tick_rise), .tick_data(tick_data),
    .tick_start(tick_start), .tick_stop(tick_stop),
    .phase_done(phase_done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int         stamp;
    logic [7:0] v;     // {oe, fall, rise, data, start, stop, done, busy}
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   nvec   = 0;
  int   nfail  = 0;
  bit   ended  = 0;

  task automatic push(input int st, input logic [7:0] v, input string tag);
    exp_t e;
    e.stamp = st; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: samples 0.5 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk); #0.5;
      cyc++;
      while (q.size() > 0 && q[0].stamp <= cyc) begin
        exp_t e;
        logic [7:0] got;
        e   = q.pop_front();
        got = {scl_oe, tick_fall, tick_rise, tick_data, tick_start, tick_stop,
               phase_done, busy};
        nvec++;
        if (e.stamp != cyc || got !== e.v) begin
          nfail++;
          $display("FAIL %s cycle %0d: got %b expected %b (stamp %0d)",
                   e.tag, cyc, got, e.v, e.stamp);
        end
      end
      if (rst_n) begin
        nvec++;
        if ($countones({tick_fall, tick_rise, tick_data, tick_start, tick_stop}) > 1) begin
          nfail++;
          $display("FAIL R11 cycle %0d: got ticks %b expected at most one",
                   cyc, {tick_fall, tick_rise, tick_data, tick_start, tick_stop});
        end
      end
    end
  end

  function automatic int c_per(input int p); return (p < 4) ? 4 : p; endfunction
  function automatic int c_low(input int l, input int pe);
    return (l < 2) ? 2 : ((l > pe - 1) ? pe - 1 : l);
  endfunction
  function automatic int c_dset(input int d, input int le);
    return (d < 1) ? 1 : ((d > le - 1) ? le - 1 : d);
  endfunction
  function automatic int c_sset(input int s); return (s < 1) ? 1 : s; endfunction

  // Idle or held cycles: drives the hold inputs and go, expects no phase.
  task automatic idle(input int n, input logic run, input logic free,
                      input logic gov, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1.5;
      run_en = run; scl_free = free; go = gov; op = 2'd1;
      push(cyc + 1, {((run && free) ? 1'b0 : !free), 7'b0}, tag);
    end
  endtask

  // Requests one phase; returns in the cycle before its phase_done cycle.
  task automatic issue(input logic [1:0] opc, input int p, input int l,
                       input int d, input int s, input bit disturb,
                       input string tag);
    int k, pe, le, de, se, len;
    @(negedge clk); #1.5;
    k = cyc;
    run_en = 1'b1; scl_free = 1'b1;
    cfg_period = CW'(p); cfg_low = CW'(l); cfg_dsetup = CW'(d); cfg_susto = CW'(s);
    op = opc; go = 1'b1;
    pe = c_per(p); le = c_low(l, pe); de = c_dset(d, le); se = c_sset(s);
    if (opc == 2'd0) begin
      len = pe;
      for (int i = 0; i < pe; i++)
        push(k + 1 + i, {1'(i < le), 1'(i == 0), 1'(i == le), 1'(i == de),
                         2'b00, 1'(i == pe - 1), 1'b1}, tag);
    end else begin
      len = 2 * se;
      for (int i = 0; i < len; i++)
        push(k + 1 + i, {4'b0000, 1'(i == se && opc != 2'd2),
                         1'(i == se && opc == 2'd2), 1'(i == len - 1), 1'b1}, tag);
    end
    for (int j = 1; j <= len - 1; j++) begin
      @(negedge clk); #1.5;
      if (j == 1) go = 1'b0;
      if (disturb && j == 2) begin
        go = 1'b1; op = 2'd1;
        cfg_period = CW'(40); cfg_low = CW'(30); cfg_dsetup = CW'(20); cfg_susto = CW'(9);
      end
      if (disturb && j == 3) go = 1'b0;
    end
  endtask

  // Watchdog
  initial begin
    #500000;
    if (!ended) begin
      nfail++;
      $display("FAIL watchdog: got no end expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b1; scl_free = 1'b1; go = 1'b0; op = 2'd0;
    cfg_period = CW'(20); cfg_low = CW'(10); cfg_dsetup = CW'(3); cfg_susto = CW'(5);
    repeat (3) @(negedge clk);
    #1.5 rst_n = 1'b1;

    idle(4, 1'b1, 1'b1, 1'b0, "R1 reset idle");
    // R2 R3 plain bit, then back-to-back phases (R9) of each op code (R10)
    issue(2'd0, 20, 10, 3, 5, 1'b0, "R2 R3 bit");
    issue(2'd1, 20, 10, 3, 4, 1'b0, "R4 R10 start");
    issue(2'd0, 16, 6, 2, 4, 1'b1, "R5 R9 bit with mid-phase request and count change");
    issue(2'd2, 16, 6, 2, 3, 1'b0, "R4 R10 stop");
    idle(3, 1'b1, 1'b1, 1'b0, "R9 idle after last phase");
    issue(2'd3, 12, 6, 1, 2, 1'b0, "R10 repeated start");
    // R6 clamps
    issue(2'd0, 2, 0, 0, 1, 1'b0, "R6 clamp period and low floor");
    issue(2'd0, 10, 15, 12, 1, 1'b0, "R6 clamp low and data ceiling");
    issue(2'd1, 10, 5, 1, 0, 1'b0, "R6 setup count floor");
    idle(2, 1'b1, 1'b1, 1'b0, "R1 idle");

    // R7 abort mid-bit: first three cycles of a bit, then hold
    @(negedge clk); #1.5;
    begin
      int k;
      k = cyc;
      cfg_period = CW'(30); cfg_low = CW'(12); cfg_dsetup = CW'(4); cfg_susto = CW'(3);
      op = 2'd0; go = 1'b1;
      push(k + 1, 8'b1100_0001, "R7 bit before abort");
      push(k + 2, 8'b1000_0001, "R7 bit before abort");
      push(k + 3, 8'b1000_0001, "R7 bit before abort");
      @(negedge clk); #1.5 go = 1'b0;
      @(negedge clk); #1.5;
    end
    idle(4, 1'b0, 1'b0, 1'b1, "R7 R8 abort and hold, SCL low, request ignored");
    idle(3, 1'b0, 1'b1, 1'b1, "R8 hold with SCL released");
    idle(3, 1'b1, 1'b0, 1'b1, "R8 enable without release keeps SCL low");
    idle(2, 1'b1, 1'b1, 1'b0, "R7 idle after hold");
    issue(2'd0, 8, 4, 2, 2, 1'b0, "R7 resume bit");
    idle(3, 1'b1, 1'b1, 1'b0, "R1 final idle");

    repeat (3) @(negedge clk);
    #1;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard: got %0d pending items expected 0", q.size());
    end
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule